// File: doc/BRIEF.md
# Dual-Strobe RAM with Conflict Abort

A small word-addressed RAM block accessed through two active-high strobes, one for reads and one for writes. Each strobe is already qualified by block selection and timing upstream, so the block reacts to a strobe only when that strobe is meant for it. The block samples the strobes on its clock. The two strobes are folded into one access event, which fires on the first clock edge where an armed block sees either strobe high.

If both strobes are high on that edge, the block aborts the access. Nothing is written, the read register is not loaded, and a one-cycle abort pulse is raised. After any access or abort, the block stays disarmed until it samples both strobes low.

Read data goes into a local output register. That register feeds a peripheral port continuously. A separate block-read input decides whether the same word is driven onto the shared bus. Write data always comes from the shared bus.

Top module: `strobe_ram`

## Requirements
- R1: After reset, local_o is 0, abort_o is 0, and the block is armed.
- R2: On an armed clock edge where wr_i=1 and rd_i=0, the word on bus_i is stored at addr_i.
- R3: On an armed clock edge where rd_i=1 and wr_i=0, local_o takes the word stored at addr_i, visible right after that edge.
- R4: On an armed clock edge where rd_i=1 and wr_i=1, no location changes and local_o keeps its value.
- R5: abort_o is high for exactly the one cycle following the edge of an R4 conflict, and is low at all other times.
- R6: Any access or conflict disarms the block. Strobes seen while disarmed are ignored: no write, no read, no abort. The block re-arms on the first clock edge that samples rd_i=0 and wr_i=0.
- R7: local_o changes only through R3 reads. It holds its value regardless of blk_rd_i.
- R8: bus_oe_o equals blk_rd_i, independent of rd_i. bus_o equals local_o when bus_oe_o=1 and is all zeros when bus_oe_o=0, which stands for a released bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Read strobe, already qualified for this block |
| wr_i | input | 1 | Write strobe, already qualified for this block |
| blk_rd_i | input | 1 | Block read: drive the read word onto the bus |
| addr_i | input | AW | Word address |
| bus_i | input | DW | Shared bus data in (write source) |
| bus_o | output | DW | Shared bus data out, zero when released |
| bus_oe_o | output | 1 | Bus output enable |
| local_o | output | DW | Persistent last-read word for a peripheral |
| abort_o | output | 1 | One-cycle pulse after a strobe conflict |

## Verification
The bench targets the following failure modes:
- **Held strobe.** A strobe held high for several cycles must act once. A design that re-triggers on level would rewrite memory or reload local_o on every cycle.
- **Late second strobe.** A second strobe that rises while the first is still high must be ignored. A design that treats it as a conflict would raise a spurious abort.
- **Unsafe conflict.** On a true simultaneous rise, a design that lets the write through would corrupt the addressed word. One that lets the read through would change local_o.
- **Coupled outputs.** Toggling block-read without reads shows whether the bus enable or the local port is wrongly tied to the read strobe.

// File: rtl/strobe_ram_pkg.sv
package strobe_ram_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_RD    = 2'd1,
    ACC_WR    = 2'd2,
    ACC_CLASH = 2'd3
  } acc_e;
endpackage

// File: rtl/strobe_arbiter.sv
module strobe_arbiter
  import strobe_ram_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic wr_i,
  output logic re_o,
  output logic we_o,
  output logic abort_o
);
  logic armed_q;
  logic abort_q;
  acc_e kind;

  always_comb begin
    kind = ACC_NONE;
    if (armed_q) begin
      unique case ({rd_i, wr_i})
        2'b10:   kind = ACC_RD;
        2'b01:   kind = ACC_WR;
        2'b11:   kind = ACC_CLASH;
        default: kind = ACC_NONE;
      endcase
    end
  end

  assign re_o    = (kind == ACC_RD);
  assign we_o    = (kind == ACC_WR);
  assign abort_o = abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      abort_q <= 1'b0;
    end else begin
      abort_q <= (kind == ACC_CLASH);
      if (kind != ACC_NONE)   armed_q <= 1'b0;
      else if (!rd_i && !wr_i) armed_q <= 1'b1;
    end
  end

  // R6
  disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && (rd_i || wr_i)) |=> !armed_q);

  // R5
  abort_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
endmodule

// File: rtl/ram_store.sv
module ram_store #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int Depth = 1 << AW;

  logic [DW-1:0] mem_q [Depth];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

  // R2
  wr_land_chk: assert property (@(posedge clk_i)
    we_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic          abort_i,
  input  logic          blk_rd_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] local_o,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o
);
  logic [DW-1:0] local_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   local_q <= '0;
    else if (re_i) local_q <= rdata_i;
  end

  assign local_o  = local_q;
  assign bus_oe_o = blk_rd_i;
  assign bus_o    = blk_rd_i ? local_q : '0;

  // R4
  clash_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |-> $stable(local_q));

  // R7
  local_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(local_q));
endmodule

// File: rtl/strobe_ram.sv
module strobe_ram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          blk_rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic [DW-1:0] local_o,
  output logic          abort_o
);
  logic          re, we;
  logic [DW-1:0] rdata;

  strobe_arbiter u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .re_o    (re),
    .we_o    (we),
    .abort_o (abort_o)
  );

  ram_store #(.AW(AW), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (we),
    .addr_i  (addr_i),
    .wdata_i (bus_i),
    .rdata_o (rdata)
  );

  out_stage #(.DW(DW)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .re_i     (re),
    .abort_i  (abort_o),
    .blk_rd_i (blk_rd_i),
    .rdata_i  (rdata),
    .local_o  (local_o),
    .bus_o    (bus_o),
    .bus_oe_o (bus_oe_o)
  );

  // R8
  oe_indep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o == blk_rd_i);
endmodule

// File: tb/sim_strobe_ram.sv
module sim_strobe_ram;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd = 1'b0, wr = 1'b0, blk = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] bus_out, loc;
  logic          oe, abort;

  int total = 0, bad = 0, cyc = 0;

  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] m_loc = '0;
  logic          m_armed = 1'b1;
  logic          m_abort = 1'b0;

  always #4 clk = ~clk;

  strobe_ram #(.AW(AW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .blk_rd_i(blk),
    .addr_i(addr), .bus_i(bus_in), .bus_o(bus_out), .bus_oe_o(oe),
    .local_o(loc), .abort_o(abort)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp<=100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h t=%0t", tag, act, expv, $time);
    end
  endtask

  function automatic string tag_of(input logic r, input logic w, input logic armed);
    if (!armed && (r || w)) return "R6";
    if (r && w) return "R4";
    if (w) return "R2";
    if (r) return "R3";
    return "R7";
  endfunction

  function automatic void model_edge(input logic r, input logic w, input logic [AW-1:0] a,
                                     input logic [DW-1:0] d);
    m_abort = 1'b0;
    if (m_armed && r && w) begin
      m_abort = 1'b1; m_armed = 1'b0;
    end else if (m_armed && w) begin
      m_mem[a] = d; m_armed = 1'b0;
    end else if (m_armed && r) begin
      m_loc = m_mem[a]; m_armed = 1'b0;
    end else if (!r && !w) begin
      m_armed = 1'b1;
    end
  endfunction

  task automatic step(input logic r, input logic w, input logic b,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    string t;
    @(negedge clk);
    rd = r; wr = w; blk = b; addr = a; bus_in = d;
    t = tag_of(r, w, m_armed);
    #1;
    chk(oe == b, "R8", oe, b);
    @(posedge clk);
    model_edge(r, w, a, d);
    #1;
    chk(loc == m_loc, t, loc, m_loc);
    chk(abort == m_abort, "R5", abort, m_abort);
    chk(bus_out == (b ? m_loc : '0), "R8", bus_out, b ? m_loc : '0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #20;
    chk(loc == '0, "R1", loc, 0);
    chk(abort == 1'b0, "R1", abort, 0);
    chk(oe == 1'b0, "R1", oe, 0);
    rst_n = 1'b1;

    // R2: fill every word, with an idle between accesses
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 1, 0, AW'(i), DW'(8'h30 + i * 7));
      step(0, 0, 0, AW'(i), '0);
    end
    // R3: read back with bus enabled
    for (int i = 0; i < DEPTH; i++) begin
      step(1, 0, 1, AW'(i), '0);
      step(0, 0, 1, AW'(i), '0);
    end
    // R4, R5: simultaneous strobes on a written word
    step(0, 0, 0, 4'd3, '0);
    step(1, 1, 0, 4'd3, 8'hEE);
    step(1, 1, 0, 4'd3, 8'hEE);
    step(0, 0, 0, 4'd3, '0);
    step(1, 0, 0, 4'd3, '0);
    chk(loc == 8'(8'h30 + 3 * 7), "R4", loc, 8'(8'h30 + 3 * 7));
    step(0, 0, 0, 4'd3, '0);
    // R6: held read, then write rising under it, must be ignored
    step(1, 0, 0, 4'd5, '0);
    step(1, 0, 0, 4'd6, '0);
    step(1, 1, 0, 4'd6, 8'h99);
    step(0, 1, 0, 4'd6, 8'h99);
    step(0, 0, 0, 4'd6, '0);
    step(1, 0, 0, 4'd6, '0);
    chk(loc == 8'(8'h30 + 6 * 7), "R6", loc, 8'(8'h30 + 6 * 7));
    step(0, 0, 0, 4'd6, '0);
    // R7, R8: block read toggled without reads; local holds, bus releases
    step(0, 0, 1, 4'd0, '0);
    step(0, 0, 0, 4'd0, '0);
    chk(loc == m_loc, "R7", loc, m_loc);
    step(0, 0, 1, 4'd1, '0);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [1:0] s;
      s = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) s = 2'b00;
      step(s[1], s[0], 1'($urandom_range(0, 1)), AW'($urandom), DW'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule